// File: doc/BRIEF.md
# Framed Reed-Solomon Systematic Encoder

This block adds Reed-Solomon parity to a stream of M-bit symbols. Each code block carries `K_SYM` information symbols, which leave the block unchanged and in the same cycle they arrive. They are followed by `N_SYM - K_SYM` parity symbols. The parity is the remainder of the message polynomial, times x^(N-K), divided by the generator polynomial g(x) = (x + a^1)(x + a^2)...(x + a^(N-K)). Here a is the generator element in GF(2^M). The field comes from a primitive polynomial parameter. When that parameter is zero, a built-in default for the chosen M is used. The code corrects up to (N-K)/2 symbol errors in each block.

Input and output each use a valid/ready/data/last stream handshake. A symbol moves only in a cycle where valid and ready are both high. A frame is the run of input symbols that ends with last high. The encoder cuts each frame into blocks of `K_SYM` symbols. A frame remainder shorter than `K_SYM` is a shortened block. It is treated as if zero symbols filled its leading positions. Those zeros are never sent, and they take no cycles. With last tied low, the input is a plain sequence of full blocks.

During the data part of a block, input ready follows output ready. The output then carries the input symbol combinationally. During the parity part, input ready is low and the output presents the parity register.

Top module: `rs_frame_encoder`

## Requirements
- R1: In the data part of a block, out_valid equals in_valid and out_data equals in_data. A symbol is accepted at the input in exactly the cycle it is taken at the output.
- R2: After the `K_SYM`-th accepted symbol of a block, exactly N-K parity symbols follow, highest-degree remainder coefficient first. out_valid stays high through all of them, and they equal the remainder of m(x)·x^(N-K) modulo g(x).
- R3: An input symbol with in_last high that comes before the block is full ends the block at once. Its parity equals that of the same symbols preceded by enough zero symbols to make `K_SYM`.
- R4: out_last is high only on the final parity symbol of a block that ended with in_last high. It is low on every data symbol and on every other parity symbol.
- R5: in_ready stays low while parity symbols are being emitted.
- R6: in_ready is low whenever out_ready is low. A parity symbol that is offered but not taken keeps its value and its out_last until it is taken.
- R7: Every block's parity depends only on that block's own symbols, with no carry-over from earlier blocks.
- R8: While reset is high and no input is offered, out_valid and out_last are low.
- R9: With `PRIM_POLY` = 0 and `SYM_W` = 4, the field polynomial is x^4 + x + 1 (0x13). `GEN_ELEM` defaults to 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input symbol offered |
| in_ready | output | 1 | Encoder can take an input symbol |
| in_data | input | SYM_W | Input information symbol |
| in_last | input | 1 | Input symbol ends the frame |
| out_valid | output | 1 | Output symbol offered |
| out_ready | input | 1 | Downstream takes the output symbol |
| out_data | output | SYM_W | Output symbol (data or parity) |
| out_last | output | 1 | Output symbol ends the frame |

## Verification
The encoder is driven with several kinds of blocks:
- A full random block and an all-zero block. These separate a correct generator polynomial from a zero or stuck parity path.
- Frames of length 1, 5, 11 and 25. These check shortening by a leading virtual zero fill against a trailing fill, and where out_last may appear.
- Back-to-back blocks under random output stalls and input gaps. These show whether the remainder register is cleared between blocks and whether a stalled parity symbol holds still.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_PAR  = 1'b1
    } phase_t;

    typedef struct packed {
        logic load;   // absorb one information symbol
        logic shift;  // emit one parity symbol
        logic clear;  // zero the remainder register
    } lfsr_cmd_t;

    // default primitive polynomials, indexed by symbol width
    function automatic int default_poly(input int m);
        case (m)
            3:       return 'h00B;
            4:       return 'h013;
            5:       return 'h025;
            6:       return 'h043;
            7:       return 'h089;
            8:       return 'h11D;
            9:       return 'h211;
            10:      return 'h409;
            default: return 'h013;
        endcase
    endfunction

    // GF(2^m) product by shift and add
    function automatic int gf_mul(input int a, input int b, input int m, input int poly);
        int acc;
        int x;
        acc = 0;
        x   = a;
        for (int i = 0; i < m; i++) begin
            if (((b >> i) & 1) != 0) acc = acc ^ x;
            x = x << 1;
            if (((x >> m) & 1) != 0) x = x ^ poly;
        end
        return acc;
    endfunction

    // coefficient idx of prod_{i=1..p} (x + alpha^i)
    function automatic int gen_coef(input int idx, input int p, input int m,
                                    input int poly, input int alpha);
        int c [0:63];
        int root;
        for (int j = 0; j < 64; j++) c[j] = 0;
        c[0] = 1;
        root = 1;
        for (int i = 1; i <= p; i++) begin
            root = gf_mul(root, alpha, m, poly);
            for (int j = i; j >= 1; j--) c[j] = c[j-1] ^ gf_mul(c[j], root, m, poly);
            c[0] = gf_mul(c[0], root, m, poly);
        end
        return c[idx];
    endfunction

endpackage

// File: rtl/rs_const_mul.sv
module rs_const_mul #(
    parameter int SYM_W = 4,
    parameter int COEF  = 1,
    parameter int POLY  = 'h13
) (
    input  logic [SYM_W-1:0] a,
    output logic [SYM_W-1:0] y
);
    logic [SYM_W-1:0] acc [0:SYM_W];

    assign acc[0] = '0;

    for (genvar i = 0; i < SYM_W; i++) begin : g_bit
        localparam int TERM = rs_pkg::gf_mul(COEF, 1 << i, SYM_W, POLY);
        localparam logic [SYM_W-1:0] TERM_V = TERM[SYM_W-1:0];
        assign acc[i+1] = acc[i] ^ (a[i] ? TERM_V : '0);
    end

    assign y = acc[SYM_W];
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr #(
    parameter int SYM_W = 4,
    parameter int PAR_N = 4,
    parameter int POLY  = 'h13,
    parameter int ALPHA = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rs_pkg::lfsr_cmd_t    cmd,
    input  logic [SYM_W-1:0]     din,
    output logic [SYM_W-1:0]     par_out
);
    logic [SYM_W-1:0] rem_q [PAR_N];
    logic [SYM_W-1:0] prod  [PAR_N];
    logic [SYM_W-1:0] fb;

    assign fb = din ^ rem_q[PAR_N-1];

    for (genvar j = 0; j < PAR_N; j++) begin : g_tap
        rs_const_mul #(
            .SYM_W(SYM_W),
            .COEF (rs_pkg::gen_coef(j, PAR_N, SYM_W, POLY, ALPHA)),
            .POLY (POLY)
        ) u_mul (
            .a(fb),
            .y(prod[j])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            for (int j = 0; j < PAR_N; j++) rem_q[j] <= '0;
        end else if (cmd.load) begin
            rem_q[0] <= prod[0];
            for (int j = 1; j < PAR_N; j++) rem_q[j] <= rem_q[j-1] ^ prod[j];
        end else if (cmd.shift) begin
            rem_q[0] <= '0;
            for (int j = 1; j < PAR_N; j++) rem_q[j] <= rem_q[j-1];
        end
    end

    assign par_out = rem_q[PAR_N-1];
endmodule

// File: rtl/rs_block_ctrl.sv
module rs_block_ctrl #(
    parameter int K_SYM = 11,
    parameter int PAR_N = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_last,
    input  logic               out_ready,
    output logic               in_ready,
    output rs_pkg::phase_t     phase,
    output rs_pkg::lfsr_cmd_t  cmd,
    output logic               par_last
);
    import rs_pkg::*;

    localparam int DW = $clog2(K_SYM + 1);
    localparam int PW = $clog2(PAR_N + 1);
    localparam logic [DW-1:0] D_END = DW'(K_SYM - 1);
    localparam logic [PW-1:0] P_END = PW'(PAR_N - 1);

    phase_t        phase_q;
    logic [DW-1:0] dcnt_q;
    logic [PW-1:0] pcnt_q;
    logic          end_q;
    logic          take;
    logic          give;

    assign in_ready = (phase_q == PH_DATA) && out_ready;
    assign take     = in_valid && in_ready;
    assign give     = (phase_q == PH_PAR) && out_ready;

    always_comb begin
        cmd.load  = take;
        cmd.shift = give;
        cmd.clear = give && (pcnt_q == P_END);
    end

    assign par_last = (phase_q == PH_PAR) && (pcnt_q == P_END) && end_q;
    assign phase    = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DATA;
            dcnt_q  <= '0;
            pcnt_q  <= '0;
            end_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_DATA: begin
                    if (take) begin
                        if (in_last || dcnt_q == D_END) begin
                            phase_q <= PH_PAR;
                            dcnt_q  <= '0;
                            pcnt_q  <= '0;
                            end_q   <= in_last;
                        end else begin
                            dcnt_q <= dcnt_q + 1'b1;
                        end
                    end
                end
                PH_PAR: begin
                    if (give) begin
                        if (pcnt_q == P_END) begin
                            phase_q <= PH_DATA;
                            pcnt_q  <= '0;
                        end else begin
                            pcnt_q <= pcnt_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_DATA;
            endcase
        end
    end
endmodule

// File: rtl/rs_frame_encoder.sv
module rs_frame_encoder #(
    parameter int SYM_W     = 4,
    parameter int N_SYM     = 15,
    parameter int K_SYM     = 11,
    parameter int PRIM_POLY = 0,
    parameter int GEN_ELEM  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SYM_W-1:0] out_data,
    output logic             out_last
);
    import rs_pkg::*;

    localparam int PAR_N      = N_SYM - K_SYM;
    localparam int FIELD_POLY = (PRIM_POLY == 0) ? default_poly(SYM_W) : PRIM_POLY;

    phase_t           phase_q;
    lfsr_cmd_t        cmd;
    logic             par_last;
    logic [SYM_W-1:0] par_sym;

    rs_block_ctrl #(
        .K_SYM(K_SYM),
        .PAR_N(PAR_N)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .phase    (phase_q),
        .cmd      (cmd),
        .par_last (par_last)
    );

    rs_parity_lfsr #(
        .SYM_W(SYM_W),
        .PAR_N(PAR_N),
        .POLY (FIELD_POLY),
        .ALPHA(GEN_ELEM)
    ) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .din    (in_data),
        .par_out(par_sym)
    );

    always_comb begin
        if (phase_q == PH_PAR) begin
            out_valid = 1'b1;
            out_data  = par_sym;
            out_last  = par_last;
        end else begin
            out_valid = in_valid;
            out_data  = in_data;
            out_last  = 1'b0;
        end
    end
endmodule

// File: rtl/rs_frame_encoder_chk.sv
module rs_frame_encoder_chk #(
    parameter int SYM_W = 4,
    parameter int N_SYM = 15,
    parameter int K_SYM = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic [SYM_W-1:0] out_data,
    input rs_pkg::phase_t   phase
);
    import rs_pkg::*;

    localparam int PAR_N = N_SYM - K_SYM;

    int par_beats;
    int dat_beats;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_beats <= 0;
            dat_beats <= 0;
        end else begin
            if (phase == PH_PAR && out_valid && out_ready) par_beats <= par_beats + 1;
            else if (phase == PH_DATA) par_beats <= 0;
            if (in_valid && in_ready) dat_beats <= dat_beats + 1;
            else if (phase == PH_PAR) dat_beats <= 0;
        end
    end

    assert_stall_blocks_input_R6: assert property (@(posedge clk) disable iff (rst)
        !out_ready |-> !in_ready);

    assert_parity_held_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAR && out_valid && !out_ready)
        |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_no_input_in_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAR) |-> !in_ready);

    assert_last_on_parity_R4: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_valid && phase == PH_PAR));

    assert_parity_count_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) == PH_PAR) |-> (par_beats == PAR_N));

    assert_block_len_R3: assert property (@(posedge clk) disable iff (rst)
        dat_beats <= K_SYM);
endmodule

bind rs_frame_encoder rs_frame_encoder_chk #(
    .SYM_W(SYM_W),
    .N_SYM(N_SYM),
    .K_SYM(K_SYM)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_last (out_last),
    .out_data (out_data),
    .phase    (phase_q)
);

// File: tb/rs_frame_encoder_test.sv
`timescale 1ns/1ps
module rs_frame_encoder_test;
    localparam int M  = 4;
    localparam int N  = 15;
    localparam int K  = 11;
    localparam int P  = N - K;
    localparam int QN = (1 << M) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [M-1:0] in_data = '0;
    logic         in_last = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [M-1:0] out_data;
    logic         out_last;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit started = 1'b0;
    int rdy_mode = 0;
    int blocks_done = 0;

    int exp_tab [0:QN-1];
    int log_tab [0:QN];
    int gpoly   [0:P];

    int    exp_d [$];
    bit    exp_l [$];
    string exp_t [$];
    int    blk   [$];

    always #2 clk = ~clk;

    rs_frame_encoder uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int fmul(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        return exp_tab[(log_tab[a] + log_tab[b]) % QN];
    endfunction

    // field from x^4+x+1 with alpha = 2 (R9)
    initial begin
        int v;
        v = 1;
        for (int i = 0; i < QN; i++) begin
            exp_tab[i] = v;
            log_tab[v] = i;
            v = v << 1;
            if (v & 16) v = v ^ 'h13;
        end
        log_tab[0] = 0;
        // gpoly[0] is the x^P coefficient (descending order)
        for (int i = 0; i <= P; i++) gpoly[i] = 0;
        gpoly[0] = 1;
        for (int r = 1; r <= P; r++) begin
            for (int j = r; j >= 1; j--) gpoly[j] = gpoly[j] ^ fmul(gpoly[j-1], exp_tab[r % QN]);
        end
    end

    // long division of the zero-filled block; pushes expected parity
    task automatic close_block(input bit fl);
        int div [0:K+P-1];
        int pad;
        string tag;
        pad = K - blk.size();
        for (int i = 0; i < K + P; i++) div[i] = 0;
        for (int i = 0; i < blk.size(); i++) div[pad + i] = blk[i];
        for (int i = 0; i < K; i++) begin
            int c;
            c = div[i];
            if (c != 0) for (int j = 0; j <= P; j++) div[i+j] = div[i+j] ^ fmul(c, gpoly[j]);
        end
        if (pad > 0)               tag = "R3";
        else if (blocks_done == 0) tag = "R2,R9";
        else                       tag = "R2,R7";
        for (int j = 0; j < P; j++) begin
            exp_d.push_back(div[K + j]);
            exp_l.push_back(fl && (j == P - 1));
            exp_t.push_back((fl && j == P - 1) ? {tag, ",R4"} : tag);
        end
        blk.delete();
        blocks_done++;
    endtask

    // reference model, compared every cycle
    always @(negedge clk) begin
        if (started && !rst) begin
            if (exp_d.size() != 0) begin
                chk(out_valid == 1'b1, "R2", out_valid, 1);
                chk(in_ready == 1'b0, "R5", in_ready, 0);
            end else begin
                chk(in_ready == out_ready, "R6", in_ready, out_ready);
                chk(out_valid == in_valid, "R1", out_valid, in_valid);
                chk(out_last == 1'b0, "R4", out_last, 0);
            end
            if (in_valid && in_ready) begin
                exp_d.push_back(in_data);
                exp_l.push_back(1'b0);
                exp_t.push_back("R1");
                blk.push_back(in_data);
                if (in_last || blk.size() == K) close_block(in_last);
            end
            if (out_valid && out_ready) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R2", out_data, -1);
                end else begin
                    int    ed;
                    bit    el;
                    string et;
                    ed = exp_d.pop_front();
                    el = exp_l.pop_front();
                    et = exp_t.pop_front();
                    chk(out_data == ed[M-1:0], et, out_data, ed);
                    chk(out_last == el, et, out_last, el);
                end
            end
        end
    end

    always begin
        @(posedge clk);
        #1;
        if (rdy_mode == 0) out_ready = 1'b1;
        else               out_ready = ($urandom_range(0, 3) != 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic put(input int d, input bit l, input int gap);
        bit ok;
        repeat (gap) begin
            @(posedge clk);
            #1;
        end
        in_data  = d[M-1:0];
        in_last  = l;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
            #1;
        end while (!ok);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send(input int len, input bit use_last, input bit zeros, input int max_gap);
        for (int i = 0; i < len; i++) begin
            int d;
            d = zeros ? 0 : $urandom_range(0, QN);
            put(d, use_last && (i == len - 1), (max_gap > 0) ? $urandom_range(0, max_gap) : 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", out_valid, 0);
        chk(out_last == 1'b0, "R8", out_last, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        started = 1'b1;

        send(K, 1'b0, 1'b0, 0);      // full block, R2 and R9
        send(K, 1'b0, 1'b1, 0);      // all-zero block gives zero parity, R2
        send(5, 1'b1, 1'b0, 0);      // shortened block, R3 and R4
        send(1, 1'b1, 1'b0, 0);      // single-symbol frame, R3
        send(K, 1'b1, 1'b0, 0);      // frame exactly one block, R4
        send(25, 1'b1, 1'b0, 0);     // two full blocks and a short one, R7
        rdy_mode = 1;
        send(4 * K, 1'b0, 1'b0, 2);  // back to back under stalls, R6 and R7
        send(17, 1'b1, 1'b0, 1);
        send(3, 1'b1, 1'b0, 0);
        rdy_mode = 0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(exp_d.size() == 0, "R2", exp_d.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule